// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block decides when a successive-approximation converter samples its input and when a conversion begins. Software sets it up through one 8-bit control register. That register selects one of several trigger sources and one of two tracking policies. The same register reports a busy bit and two sticky interrupt flags. The block sends a track level and a one-cycle convert-start strobe to the converter. It takes back a done pulse, which ends the conversion.

Two tracking policies are available. In the continuous policy the converter tracks whenever it is enabled and idle, and a trigger starts conversion in the next cycle. In the low-power policy a trigger first opens a track window of a fixed number of SAR-clock-enabled cycles, and conversion follows the window. In the external-pin mode of this policy, tracking follows the low level of the pin and conversion starts on its rising edge. The trigger can also be taken from the software-start strobe of a companion converter.

Top module: `adc_start_seq`

## Requirements
- R1: Control register layout, MSB first: bit 7 enable, bit 6 low-power track, bit 5 done flag, bit 4 busy, bits 3..1 start mode, bit 0 window flag. After reset the register reads 0x00 and trackOut, convStart and busyOut are 0.
- R2: While enable is 0 every trigger is ignored and trackOut stays 0.
- R3: A write with bit 4 = 1 starts a conversion only when that write also sets start mode 000. Writing bit 4 = 0, or bit 4 = 1 with any other mode, starts nothing.
- R4: Start mode 000 selects the software busy write, 001 the Timer 3 overflow, 010 a rising edge of the external pin, 011 the Timer 2 overflow, and 1xx the companion converter's start strobe. Triggers from sources that are not selected are ignored.
- R5: With low-power track = 0, trackOut is 1 whenever the block is enabled and idle. A trigger seen at a clock edge raises convStart in the cycle right after that edge.
- R6: With low-power track = 1 and a mode other than 010, trackOut is 0 while idle. A trigger opens a window of exactly TRACK_CLKS (default 3) SAR-enabled cycles, and convStart follows that window.
- R7: With low-power track = 1 and mode 010, trackOut follows the synchronized pin being low while idle, and a rising edge starts conversion without a window.
- R8: busyOut is 1 from trigger acceptance until the done pulse. convStart lasts exactly one cycle. The done flag (and doneIrq) is set as busyOut falls at the end of a conversion.
- R9: The done flag and the window flag are sticky. Only a write with that bit at 0 clears them, and writing 1 to them has no effect.
- R10: The external pin passes through a two-flop synchronizer. In continuous tracking with mode 010, convStart rises in the third cycle after the pin goes high.
- R11: The track window advances only in cycles where sarClkEn is 1. Triggers that arrive during tracking or conversion are ignored.
- R12: If a hardware set and a software clear of the same flag fall in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Control register read value |
| sarClkEn | input | 1 | SAR clock enable, paces the track window |
| tmr2Ovf | input | 1 | Timer 2 overflow pulse |
| tmr3Ovf | input | 1 | Timer 3 overflow pulse |
| extStartPin | input | 1 | Asynchronous external convert-start pin |
| peerSwStart | input | 1 | Companion converter software-start strobe |
| convDone | input | 1 | Converter finished pulse |
| winHit | input | 1 | Window compare match pulse |
| trackOut | output | 1 | Converter track level |
| convStart | output | 1 | One-cycle convert-start strobe |
| busyOut | output | 1 | Conversion sequence in progress |
| doneIrq | output | 1 | Sticky conversion-complete flag |
| winIrq | output | 1 | Sticky window-compare flag |

## Verification
The hardest case to reach is a low-power track window whose length depends on a gapped SAR clock enable. It gets harder when stray triggers arrive during that window. The bench reaches it in two ways. It toggles sarClkEn every cycle during one window and counts the enabled cycles that trackOut spans. It also fires random pulses on every trigger input while a conversion is in flight. A further case is a hardware set and a software clear of a flag in the same cycle. The bench lines up a done pulse or a window hit with a clearing register write on one clock edge to produce it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam logic [2:0] MODE_SW   = 3'b000;
  localparam logic [2:0] MODE_TMR3 = 3'b001;
  localparam logic [2:0] MODE_PIN  = 3'b010;
  localparam logic [2:0] MODE_TMR2 = 3'b011;

  // register bit positions
  localparam int BIT_EN   = 7;
  localparam int BIT_LP   = 6;
  localparam int BIT_DONE = 5;
  localparam int BIT_BUSY = 4;
  localparam int BIT_WIN  = 0;

  typedef struct packed {
    logic       en;
    logic       lowPwr;
    logic [2:0] mode;
  } cfgT;

  typedef struct packed {
    logic setDone;
    logic busy;
  } ctrlStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_CONV  = 2'd2
  } seqStateT;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       winHit,
  input  logic       extStartPin,
  input  ctrlStrobeT ctrlIn,
  output cfgT        cfg,
  output logic [7:0] regRdData,
  output logic       swStart,
  output logic       pinLevel,
  output logic       pinRise,
  output logic       doneFlag,
  output logic       winFlag
);

  localparam int STAGES = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [STAGES-1:0] syncQ;
  logic              pinPrev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else if (g == 0) syncQ[g] <= extStartPin;
        else syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign pinLevel = syncQ[STAGES-1];
  assign pinRise  = pinLevel & ~pinPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg      <= '0;
      swStart  <= 1'b0;
      doneFlag <= 1'b0;
      winFlag  <= 1'b0;
      pinPrev  <= 1'b0;
    end else begin
      pinPrev <= pinLevel;
      swStart <= regWrEn & regWrData[BIT_BUSY] & (regWrData[3:1] == MODE_SW);
      if (regWrEn) begin
        cfg.en     <= regWrData[BIT_EN];
        cfg.lowPwr <= regWrData[BIT_LP];
        cfg.mode   <= regWrData[3:1];
      end
      if (ctrlIn.setDone) doneFlag <= 1'b1;
      else if (regWrEn && !regWrData[BIT_DONE]) doneFlag <= 1'b0;
      if (winHit) winFlag <= 1'b1;
      else if (regWrEn && !regWrData[BIT_WIN]) winFlag <= 1'b0;
    end
  end

  assign regRdData = {cfg.en, cfg.lowPwr, doneFlag, ctrlIn.busy, cfg.mode, winFlag};

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int TRACK_CLKS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgT        cfg,
  input  logic       sarClkEn,
  input  logic       tmr2Ovf,
  input  logic       tmr3Ovf,
  input  logic       swStart,
  input  logic       pinRise,
  input  logic       pinLevel,
  input  logic       peerSwStart,
  input  logic       convDone,
  output ctrlStrobeT ctrlOut,
  output logic       trackOut,
  output logic       convStart
);

  localparam int CNT_W = (TRACK_CLKS > 1) ? $clog2(TRACK_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRACK_CLKS - 1);

  seqStateT        st, nxt;
  logic [CNT_W-1:0] cnt;
  logic            trig, goConv, directConv;

  always_comb begin
    casez (cfg.mode)
      MODE_SW:   trig = swStart;
      MODE_TMR3: trig = tmr3Ovf;
      MODE_PIN:  trig = pinRise;
      MODE_TMR2: trig = tmr2Ovf;
      default:   trig = peerSwStart;
    endcase
  end

  assign directConv = !cfg.lowPwr || (cfg.mode == MODE_PIN);

  always_comb begin
    nxt    = st;
    goConv = 1'b0;
    case (st)
      ST_IDLE: begin
        if (cfg.en && trig) begin
          if (directConv) begin
            nxt    = ST_CONV;
            goConv = 1'b1;
          end else begin
            nxt = ST_TRACK;
          end
        end
      end
      ST_TRACK: begin
        if (sarClkEn && cnt == CNT_LAST) begin
          nxt    = ST_CONV;
          goConv = 1'b1;
        end
      end
      ST_CONV: if (convDone) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    if (!cfg.en) begin
      nxt    = ST_IDLE;
      goConv = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      convStart <= 1'b0;
    end else begin
      st        <= nxt;
      convStart <= goConv;
      if (st != ST_TRACK) cnt <= '0;
      else if (sarClkEn) cnt <= cnt + 1'b1;
    end
  end

  assign ctrlOut.setDone = (st == ST_CONV) && convDone;
  assign ctrlOut.busy    = (st != ST_IDLE);

  always_comb begin
    trackOut = 1'b0;
    if (cfg.en) begin
      if (st == ST_TRACK) trackOut = 1'b1;
      else if (st == ST_IDLE) begin
        if (!cfg.lowPwr) trackOut = 1'b1;
        else if (cfg.mode == MODE_PIN) trackOut = !pinLevel;
      end
    end
  end

endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
  import adc_seq_pkg::*;
#(
  parameter int TRACK_CLKS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       sarClkEn,
  input  logic       tmr2Ovf,
  input  logic       tmr3Ovf,
  input  logic       extStartPin,
  input  logic       peerSwStart,
  input  logic       convDone,
  input  logic       winHit,
  output logic       trackOut,
  output logic       convStart,
  output logic       busyOut,
  output logic       doneIrq,
  output logic       winIrq
);

  cfgT        cfg;
  ctrlStrobeT strobes;
  logic       swStart, pinLevel, pinRise;

  adc_seq_regs #(.SYNC_STAGES(SYNC_STAGES)) regs_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .winHit(winHit), .extStartPin(extStartPin), .ctrlIn(strobes),
    .cfg(cfg), .regRdData(regRdData), .swStart(swStart),
    .pinLevel(pinLevel), .pinRise(pinRise),
    .doneFlag(doneIrq), .winFlag(winIrq)
  );

  adc_seq_ctrl #(.TRACK_CLKS(TRACK_CLKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfg(cfg), .sarClkEn(sarClkEn),
    .tmr2Ovf(tmr2Ovf), .tmr3Ovf(tmr3Ovf), .swStart(swStart),
    .pinRise(pinRise), .pinLevel(pinLevel), .peerSwStart(peerSwStart),
    .convDone(convDone), .ctrlOut(strobes),
    .trackOut(trackOut), .convStart(convStart)
  );

  assign busyOut = strobes.busy;

endmodule

// File: rtl/adc_start_seq_chk.sv
module adc_start_seq_chk #(
  parameter int TRACK_CLKS = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [7:0] regRdData,
  input logic       sarClkEn,
  input logic       convDone,
  input logic       winHit,
  input logic       trackOut,
  input logic       convStart,
  input logic       busyOut,
  input logic       doneIrq,
  input logic       winIrq
);

  localparam int TW = $clog2(TRACK_CLKS + 2) + 1;
  localparam logic [TW-1:0] TMAX = '1;

  logic [TW-1:0] trkCnt;

  always_ff @(posedge clk) begin
    if (!rstN) trkCnt <= '0;
    else if (!trackOut) trkCnt <= '0;
    else if (sarClkEn && trkCnt != TMAX) trkCnt <= trkCnt + 1'b1;
  end

  p_track_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[7] |-> !trackOut);

  p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> busyOut);

  p_done_on_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyOut) && $past(convDone) |-> doneIrq);

  p_sticky_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(doneIrq) && !$past(regWrEn) |-> doneIrq);

  p_sticky_win_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(winIrq) && !$past(regWrEn) |-> winIrq);

  p_win_set_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    $past(winHit) |-> winIrq);

  p_lp_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    convStart && $past(regRdData[7]) && $past(regRdData[6]) &&
    ($past(regRdData[3:1]) != 3'b010) |-> trkCnt == TW'(TRACK_CLKS));

endmodule

bind adc_start_seq adc_start_seq_chk #(.TRACK_CLKS(TRACK_CLKS)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdData(regRdData),
  .sarClkEn(sarClkEn), .convDone(convDone), .winHit(winHit),
  .trackOut(trackOut), .convStart(convStart), .busyOut(busyOut),
  .doneIrq(doneIrq), .winIrq(winIrq)
);

// File: tb/adc_start_seq_tb.sv
module adc_start_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TRK = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       sarClkEn = 1'b1;
  logic       tmr2Ovf = 1'b0, tmr3Ovf = 1'b0, extStartPin = 1'b1;
  logic       peerSwStart = 1'b0, convDone = 1'b0, winHit = 1'b0;
  logic       trackOut, convStart, busyOut, doneIrq, winIrq;
  logic       gateEn = 1'b0;
  int         nChecks = 0, nFails = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) sarClkEn <= gateEn ? ~sarClkEn : 1'b1;

  adc_start_seq #(.TRACK_CLKS(TRK)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .sarClkEn(sarClkEn), .tmr2Ovf(tmr2Ovf),
    .tmr3Ovf(tmr3Ovf), .extStartPin(extStartPin), .peerSwStart(peerSwStart),
    .convDone(convDone), .winHit(winHit), .trackOut(trackOut),
    .convStart(convStart), .busyOut(busyOut), .doneIrq(doneIrq), .winIrq(winIrq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expTrackIdle(input logic [7:0] cfg);
    return cfg[7] && !cfg[6];
  endfunction

  function automatic logic [7:0] pickMode(input int m);
    case (m)
      0: return 8'h00;
      1: return 8'h02;
      2: return 8'h06;
      default: return 8'((m + 1) << 1);
    endcase
  endfunction

  task automatic writeReg(input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishDone(input string req);
    pulse(convDone);
    chk(busyOut == 1'b0, req, busyOut, 0);
    chk(doneIrq == 1'b1, req, doneIrq, 1);
  endtask

  // fire selected trigger; returns at the negedge after the FSM accepted it
  task automatic fire(input logic [7:0] cfg);
    case (cfg[3:1])
      3'b000: begin writeReg(cfg | 8'h10); @(negedge clk); end
      3'b001: pulse(tmr3Ovf);
      3'b011: pulse(tmr2Ovf);
      default: pulse(peerSwStart);
    endcase
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(regRdData == 8'h00, "R1", regRdData, 0);
    chk(!trackOut && !convStart && !busyOut, "R1", {trackOut, convStart, busyOut}, 0);

    // R2 disabled, timer 3 mode
    writeReg(8'h02);
    pulse(tmr3Ovf);
    idle(2);
    chk(!busyOut && !convStart, "R2", busyOut, 0);
    chk(!trackOut, "R2", trackOut, 0);

    // R5 continuous tracking, timer 3
    writeReg(8'h82);
    chk(trackOut == 1'b1, "R5", trackOut, 1);
    pulse(tmr3Ovf);
    chk(convStart && busyOut && !trackOut, "R5", {convStart, busyOut, trackOut}, 3'b110);
    @(negedge clk);
    chk(!convStart, "R8", convStart, 0);
    // R11 triggers during conversion ignored
    pulse(tmr3Ovf);
    chk(!convStart && busyOut, "R11", convStart, 0);
    // R4 unselected timer 2 ignored
    finishDone("R8");
    pulse(tmr2Ovf);
    chk(!convStart && !busyOut, "R4", busyOut, 0);

    // R9 sticky done
    writeReg(8'hA2);
    chk(doneIrq == 1'b1, "R9", doneIrq, 1);
    writeReg(8'h82);
    chk(doneIrq == 1'b0, "R9", doneIrq, 0);

    // R3 busy write with non-zero mode, then zero busy bit
    writeReg(8'h92);
    idle(2);
    chk(!busyOut, "R3", busyOut, 0);
    writeReg(8'h80);
    idle(2);
    chk(!busyOut, "R3", busyOut, 0);
    writeReg(8'h90);
    @(negedge clk);
    chk(convStart && busyOut, "R3", convStart, 1);
    finishDone("R3");
    writeReg(8'h80);

    // R6 low-power, timer 2
    writeReg(8'hC6);
    chk(!trackOut, "R6", trackOut, 0);
    pulse(tmr2Ovf);
    for (int i = 0; i < TRK; i++) begin
      chk(trackOut && !convStart && busyOut, "R6", trackOut, 1);
      @(negedge clk);
    end
    chk(convStart && !trackOut, "R6", convStart, 1);
    finishDone("R6");
    writeReg(8'hC6);

    // R11 gapped SAR clock enable during window
    gateEn = 1'b1;
    pulse(tmr2Ovf);
    begin
      int tot = 0, en = 0;
      for (int i = 0; i < 20 && trackOut; i++) begin
        tot++;
        if (sarClkEn) en++;
        if (peerSwStart == 1'b0) tmr2Ovf = 1'b1;
        @(negedge clk);
        tmr2Ovf = 1'b0;
      end
      chk(en == TRK, "R11", en, TRK);
      chk(tot > TRK, "R11", tot, TRK + 1);
      chk(convStart == 1'b1, "R11", convStart, 1);
    end
    gateEn = 1'b0;
    finishDone("R11");
    writeReg(8'h80);

    // R7 low-power pin mode (pin currently high)
    writeReg(8'hC4);
    chk(!trackOut, "R7", trackOut, 0);
    @(negedge clk); extStartPin = 1'b0;
    @(negedge clk);
    chk(!trackOut, "R7", trackOut, 0);
    @(negedge clk);
    chk(trackOut, "R7", trackOut, 1);
    extStartPin = 1'b1;
    idle(2);
    chk(!convStart, "R7", convStart, 0);
    @(negedge clk);
    chk(convStart && !trackOut, "R7", convStart, 1);
    finishDone("R7");

    // R10 continuous pin mode, three-cycle latency
    writeReg(8'h84);
    extStartPin = 1'b0;
    idle(4);
    extStartPin = 1'b1;
    @(negedge clk);
    chk(!convStart, "R10", convStart, 0);
    @(negedge clk);
    chk(!convStart, "R10", convStart, 0);
    @(negedge clk);
    chk(convStart, "R10", convStart, 1);
    // R12 done set and clear in one cycle
    @(negedge clk);
    convDone = 1'b1; regWrEn = 1'b1; regWrData = 8'h84;
    @(negedge clk);
    convDone = 1'b0; regWrEn = 1'b0;
    chk(doneIrq == 1'b1, "R12", doneIrq, 1);

    // R12 window flag
    pulse(winHit);
    chk(winIrq, "R12", winIrq, 1);
    @(negedge clk);
    winHit = 1'b1; regWrEn = 1'b1; regWrData = 8'h84;
    @(negedge clk);
    winHit = 1'b0; regWrEn = 1'b0;
    chk(winIrq, "R12", winIrq, 1);
    writeReg(8'h85);
    chk(winIrq, "R9", winIrq, 1);
    writeReg(8'h84);
    chk(!winIrq && !doneIrq, "R9", winIrq, 0);

    // R4 companion start, mode 111
    writeReg(8'h8E);
    pulse(tmr3Ovf);
    chk(!busyOut, "R4", busyOut, 0);
    pulse(peerSwStart);
    chk(convStart, "R4", convStart, 1);
    finishDone("R4");
    writeReg(8'h8E);

    // constrained random: modes other than pin
    void'($urandom(32'h5EED1234));
    for (int it = 0; it < 40; it++) begin
      logic [7:0] cfg;
      int wait_n;
      cfg = 8'h80 | pickMode($urandom_range(0, 5)) | ($urandom_range(0, 1) ? 8'h40 : 8'h00);
      writeReg(cfg);
      @(negedge clk);
      chk(trackOut == expTrackIdle(cfg), cfg[6] ? "R6" : "R5", trackOut, expTrackIdle(cfg));
      fire(cfg);
      if (cfg[6]) begin
        for (int i = 0; i < TRK; i++) begin
          chk(trackOut && !convStart, "R6", convStart, 0);
          @(negedge clk);
        end
      end
      chk(convStart && busyOut, "R4", convStart, 1);
      wait_n = $urandom_range(1, 6);
      for (int i = 0; i < wait_n; i++) begin
        @(negedge clk);
        tmr2Ovf = 1'($urandom_range(0, 1));
        tmr3Ovf = 1'($urandom_range(0, 1));
        peerSwStart = 1'($urandom_range(0, 1));
        chk(!convStart && busyOut, "R11", convStart, 0);
      end
      @(negedge clk);
      tmr2Ovf = 1'b0; tmr3Ovf = 1'b0; peerSwStart = 1'b0;
      chk(!convStart, "R11", convStart, 0);
      finishDone("R8");
      writeReg(cfg);
      chk(!doneIrq, "R9", doneIrq, 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule